// File: doc/BRIEF.md
# Multi-Channel Conversion Start Scheduler

This block is the digital front end that decides when each of four converter channels gets a conversion. Software writes one 8-bit control register. The register holds an enable, a pipeline-flush strobe, four start-request bits and a two-bit field that selects how completion requests are grouped for DMA. Requests that are pending go into a pipelined conversion engine one per cycle, lowest channel first. Each start bit reads back as cleared once its conversion has been issued, which is earlier than the moment the conversion finishes.

The conversion engine sits outside the block. It accepts an issue strobe with a channel index and returns a completion with a channel index a fixed `LAT` cycles later. The block shadows every conversion in flight. It accepts a completion only if that completion matches a conversion the block issued exactly `LAT` cycles before, and no flush has happened since. A flush aborts everything in flight, and any results that come back late are dropped. Requests not yet issued survive the flush and continue in order afterwards. Each accepted completion marks that channel's result as ready. The ready results drive per-channel DMA requests, or one shared request for channels 0–1, 0–2 or 0–3.

Top module: `conv_start_sched`

## Requirements
- R1: After reset, `rd_data` is 0x00, `dma_req` is 0 and `issue_valid` is 0. A write stores the grouping field (bits 7:6) and the enable (bit 0), and both read back at the same positions from the cycle after the write.
- R2: A written 1 in bit 2+c (c = 0..3) makes channel c pending, and several ones make several channels pending. A written 0 leaves a pending request untouched. Pending requests read back in bits 5:2.
- R3: While enabled and not flushing, the block issues one pending channel per cycle, always the lowest-numbered one, in the cycle after the write that made it pending. `issue_ch` is the channel index.
- R4: A channel's start bit reads 0 from the cycle after the cycle in which it is issued.
- R5: A write with bit 1 set drives `pipe_flush` high for exactly the following cycle. No issue happens in that cycle. A completion for any conversion issued before the flush never sets a result.
- R6: Requests still pending when a flush occurs stay pending, and they are issued in ascending order after the flush cycle.
- R7: Bit 1 of `rd_data` always reads 0.
- R8: While enable is 0, nothing is issued, and pending start bits are held until enable is set.
- R9: Rewriting a start bit for a channel that is already pending and not yet issued produces only one conversion.
- R10: With grouping 00, an accepted completion for channel c raises `dma_req[c]` in the cycle after the completion. `dma_req[c]` stays high until a cycle in which `dma_ack[c]` is high.
- R11: With grouping g = 01, 10 or 11, channels 0..g form the group. `dma_req[0]` is high only while every channel in the group has a ready result, and the other group bits of `dma_req` stay 0. `dma_ack[0]` clears the whole group, and acks on other group channels have no effect. Channels outside the group behave as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: [7:6] grouping, [5:2] starts, [1] flush, [0] enable |
| rd_data | output | 8 | Control register readback, same layout, bit 1 always 0 |
| issue_valid | output | 1 | A conversion is issued to the engine this cycle |
| issue_ch | output | 2 | Channel of the issued conversion |
| pipe_flush | output | 1 | One-cycle abort strobe to the engine |
| cmp_valid | input | 1 | Engine reports a finished conversion |
| cmp_ch | input | 2 | Channel of the finished conversion |
| dma_req | output | 4 | Per-channel or shared (bit 0) DMA request |
| dma_ack | input | 4 | Per-channel DMA acknowledge; bit 0 acknowledges a shared request |

## Verification
A write is visible on `rd_data` one cycle after its clock edge, and a newly pending channel issues in that same cycle. Each later pending channel issues one cycle after the one before it. The flush strobe appears in the cycle after the flush write. A completion comes back `LAT` cycles after its issue, and the matching DMA request rises one cycle after that, so a single start shows on `dma_req` `LAT`+1 cycles after the write edge. The bench drives inputs on the falling edge, updates a reference model on the rising edge, and compares every output on each falling edge. This way each expected value is sampled exactly one register stage after its cause. The directed checks wait out the same counts before they read the ports.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [1:0] {GRP_NONE, GRP_01, GRP_012, GRP_0123} grp_e;

  // Index of the lowest set bit (0 when none set).
  function automatic logic [CW-1:0] first_set(input logic [NCH-1:0] v);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) idx = CW'(i);
    return idx;
  endfunction

  // Channels merged into the shared request for grouping g.
  function automatic logic [NCH-1:0] group_mask(input logic [1:0] g);
    logic [NCH-1:0] m;
    m = '0;
    for (int i = 0; i < NCH; i++)
      if (g != 2'd0 && i <= int'(g)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [NCH-1:0] ch_bit(input logic [CW-1:0] c);
    return NCH'(1) << c;
  endfunction
endpackage

// File: rtl/start_queue.sv
module start_queue
  import conv_sched_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_mask,
  input  logic           en,
  input  logic           hold,
  output logic [NCH-1:0] pend,
  output logic           issue_valid,
  output logic [CW-1:0]  issue_ch
);
  logic [NCH-1:0] issue_mask;

  always_comb begin
    issue_valid = en && !hold && (pend != '0);
    issue_ch    = first_set(pend);
    issue_mask  = issue_valid ? ch_bit(issue_ch) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~issue_mask) | set_mask;
  end
endmodule

// File: rtl/inflight_track.sv
module inflight_track
  import conv_sched_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          issue_valid,
  input  logic [CW-1:0] issue_ch,
  input  logic          cmp_valid,
  input  logic [CW-1:0] cmp_ch,
  output logic          cmp_accept,
  output logic [CW-1:0] accept_ch
);
  logic [LAT-1:0] slot_v;
  logic [CW-1:0]  slot_c [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) slot_v[0] <= 1'b0;
    else                 slot_v[0] <= issue_valid;
    slot_c[0] <= issue_ch;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n || flush) slot_v[s] <= 1'b0;
      else                 slot_v[s] <= slot_v[s-1];
      slot_c[s] <= slot_c[s-1];
    end
  end

  assign cmp_accept = cmp_valid && slot_v[LAT-1] && (slot_c[LAT-1] == cmp_ch) && !flush;
  assign accept_ch  = cmp_ch;
endmodule

// File: rtl/dma_merge.sv
module dma_merge
  import conv_sched_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     grp,
  input  logic           set_valid,
  input  logic [CW-1:0]  set_ch,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] dma_req
);
  logic [NCH-1:0] ready, gmask, clr, set;

  always_comb begin
    gmask = group_mask(grp);
    set   = set_valid ? ch_bit(set_ch) : '0;
    if (grp == GRP_NONE) clr = ack;
    else                 clr = (ack & ~gmask) | (ack[0] ? gmask : '0);
    if (grp == GRP_NONE) begin
      dma_req = ready;
    end else begin
      dma_req    = ready & ~gmask;
      dma_req[0] = ((ready & gmask) == gmask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ready <= '0;
    else        ready <= (ready & ~clr) | set;
  end
endmodule

// File: rtl/conv_start_sched.sv
module conv_start_sched
  import conv_sched_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  output logic [7:0]     rd_data,
  output logic           issue_valid,
  output logic [CW-1:0]  issue_ch,
  output logic           pipe_flush,
  input  logic           cmp_valid,
  input  logic [CW-1:0]  cmp_ch,
  output logic [NCH-1:0] dma_req,
  input  logic [NCH-1:0] dma_ack
);
  logic           en_q;
  logic           flush_q;
  logic [1:0]     grp_q;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] start_w;
  logic           cmp_accept;
  logic [CW-1:0]  accept_ch;

  assign start_w = wr_en ? wr_data[2 +: NCH] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      grp_q   <= GRP_NONE;
    end else begin
      flush_q <= wr_en && wr_data[1];
      if (wr_en) begin
        en_q  <= wr_data[0];
        grp_q <= wr_data[7:6];
      end
    end
  end

  start_queue u_queue (
    .clk(clk), .rst_n(rst_n), .set_mask(start_w), .en(en_q), .hold(flush_q),
    .pend(pend), .issue_valid(issue_valid), .issue_ch(issue_ch)
  );

  inflight_track #(.LAT(LAT)) u_track (
    .clk(clk), .rst_n(rst_n), .flush(flush_q), .issue_valid(issue_valid),
    .issue_ch(issue_ch), .cmp_valid(cmp_valid), .cmp_ch(cmp_ch),
    .cmp_accept(cmp_accept), .accept_ch(accept_ch)
  );

  dma_merge u_dma (
    .clk(clk), .rst_n(rst_n), .grp(grp_q), .set_valid(cmp_accept),
    .set_ch(accept_ch), .ack(dma_ack), .dma_req(dma_req)
  );

  assign pipe_flush = flush_q;
  assign rd_data    = {grp_q, pend, 1'b0, en_q};
endmodule

// File: rtl/conv_start_sched_chk.sv
module conv_start_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_start,
  input logic [1:0] ctl_grp,
  input logic [3:0] ctl_start,
  input logic       ctl_en,
  input logic       issue_valid,
  input logic [1:0] issue_ch,
  input logic       pipe_flush,
  input logic [3:0] dma_req,
  input logic       cmp_accept,
  input logic [1:0] accept_ch
);
  // R3: nothing below the issued channel is still pending
  a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((ctl_start & ((4'b1 << issue_ch) - 4'b1)) == 4'b0));

  // R4: issued start bit reads cleared next cycle unless rewritten
  a_r4_clear_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !(wr_en && ((wr_start & (4'b1 << issue_ch)) != 4'b0)))
      |=> ((ctl_start & (4'b1 << $past(issue_ch))) == 4'b0));

  // R8: disabled means no issue
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !issue_valid);

  // R5: flush cycle issues nothing
  a_r5_flush_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |-> !issue_valid);

  // R5: flush cycle accepts no completion
  a_r5_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |-> !cmp_accept);

  // R10: accepted completion raises its request next cycle in ungrouped mode
  a_r10_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_accept && ctl_grp == 2'b00 && !wr_en)
      |=> ((dma_req & (4'b1 << $past(accept_ch))) != 4'b0));
endmodule

bind conv_start_sched conv_start_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_data[5:2]),
  .ctl_grp(rd_data[7:6]), .ctl_start(rd_data[5:2]), .ctl_en(rd_data[0]),
  .issue_valid(issue_valid), .issue_ch(issue_ch), .pipe_flush(pipe_flush),
  .dma_req(dma_req), .cmp_accept(cmp_accept), .accept_ch(accept_ch)
);

// File: tb/conv_start_sched_tb.sv
module conv_start_sched_tb;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       issue_valid;
  logic [1:0] issue_ch;
  logic       pipe_flush;
  logic       cmp_valid;
  logic [1:0] cmp_ch;
  logic [3:0] dma_req;
  logic [3:0] dma_ack = 4'h0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  conv_start_sched #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .issue_valid(issue_valid), .issue_ch(issue_ch), .pipe_flush(pipe_flush),
    .cmp_valid(cmp_valid), .cmp_ch(cmp_ch), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  // Engine stub: fixed latency, ignores the flush so stale results do come back.
  logic [LAT-1:0] st_v;
  logic [1:0]     st_c [LAT];
  always_ff @(posedge clk) begin
    if (!rst_n) st_v <= '0;
    else        st_v <= {st_v[LAT-2:0], issue_valid};
    st_c[0] <= issue_ch;
    for (int i = 1; i < LAT; i++) st_c[i] <= st_c[i-1];
  end
  assign cmp_valid = st_v[LAT-1];
  assign cmp_ch    = st_c[LAT-1];

  // Reference model.
  logic [3:0] m_pend, m_done;
  logic       m_en, m_fl;
  logic [1:0] m_grp;
  logic [LAT-1:0] m_tv;
  logic [1:0] m_tc [LAT];

  function automatic int low_ch(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return 0;
  endfunction

  function automatic logic [3:0] members(input logic [1:0] g);
    case (g)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b0111;
      2'b11:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] exp_req(input logic [3:0] d, input logic [1:0] g);
    logic [3:0] r;
    if (g == 2'b00) return d;
    r = d & ~members(g);
    r[0] = ((d & members(g)) == members(g));
    return r;
  endfunction

  always @(posedge clk) begin
    bit iss, acc;
    int ic;
    logic [3:0] clr;
    if (!rst_n) begin
      m_pend = 0; m_done = 0; m_en = 0; m_fl = 0; m_grp = 0; m_tv = 0;
    end else begin
      iss = m_en && !m_fl && (m_pend != 0);
      ic  = low_ch(m_pend);
      acc = cmp_valid && m_tv[LAT-1] && (m_tc[LAT-1] == cmp_ch) && !m_fl;
      if (m_grp == 2'b00) clr = dma_ack;
      else clr = (dma_ack & ~members(m_grp)) | (dma_ack[0] ? members(m_grp) : 4'b0);
      m_done = (m_done & ~clr) | (acc ? (4'b1 << cmp_ch) : 4'b0);
      for (int i = LAT - 1; i > 0; i--) begin
        m_tv[i] = m_fl ? 1'b0 : m_tv[i-1];
        m_tc[i] = m_tc[i-1];
      end
      m_tv[0] = m_fl ? 1'b0 : iss;
      m_tc[0] = 2'(ic);
      if (iss) m_pend[ic] = 1'b0;
      m_fl = wr_en && wr_data[1];
      if (wr_en) begin
        m_pend = m_pend | wr_data[5:2];
        m_en   = wr_data[0];
        m_grp  = wr_data[7:6];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle model comparison.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic e_iss;
      e_iss = m_en && !m_fl && (m_pend != 0);
      chk(rd_data == {m_grp, m_pend, 1'b0, m_en}, "R1 R2 R4 R7 readback", rd_data, {m_grp, m_pend, 1'b0, m_en});
      chk(issue_valid == e_iss, "R3 R8 issue", issue_valid, e_iss);
      if (e_iss) chk(issue_ch == 2'(low_ch(m_pend)), "R3 order", issue_ch, low_ch(m_pend));
      chk(pipe_flush == m_fl, "R5 flush strobe", pipe_flush, m_fl);
      chk(dma_req == exp_req(m_done, m_grp), "R10 R11 dma", dma_req, exp_req(m_done, m_grp));
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack(input logic [3:0] m);
    @(negedge clk); dma_ack = m;
    @(negedge clk); dma_ack = 4'h0;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h00, "R1 reset rd", rd_data, 0);
    chk(dma_req == 4'h0, "R1 reset dma", dma_req, 0);
    chk(issue_valid == 1'b0, "R1 reset issue", issue_valid, 0);
    wr(8'hC1);
    chk(rd_data == 8'hC1, "R1 field readback", rd_data, 8'hC1);
    wr(8'h01);

    // R2 R3 R4: two channels pending
    wr(8'h29);
    chk(rd_data == 8'h29, "R2 both pending", rd_data, 8'h29);
    chk(issue_valid && issue_ch == 2'd1, "R3 ch1 first", issue_ch, 1);
    @(negedge clk);
    chk(rd_data == 8'h21, "R4 ch1 cleared", rd_data, 8'h21);
    chk(issue_valid && issue_ch == 2'd3, "R3 ch3 next", issue_ch, 3);
    @(negedge clk);
    chk(rd_data == 8'h01 && !issue_valid, "R4 all cleared", rd_data, 8'h01);
    repeat (8) @(negedge clk);
    chk(dma_req == 4'b1010, "R10 per-channel req", dma_req, 4'b1010);
    ack(4'b0010);
    chk(dma_req == 4'b1000, "R10 ack ch1", dma_req, 4'b1000);
    ack(4'b1000);
    chk(dma_req == 4'b0000, "R10 ack ch3", dma_req, 0);

    // R8 disabled holds requests
    wr(8'h3C);
    repeat (4) begin
      chk(!issue_valid && rd_data == 8'h3C, "R8 held while off", rd_data, 8'h3C);
      @(negedge clk);
    end
    wr(8'h01);
    for (int c = 0; c < 4; c++) begin
      chk(issue_valid && issue_ch == 2'(c), "R3 ascending sweep", issue_ch, c);
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    ack(4'hF);

    // R9 merge of repeated start
    wr(8'h04);
    wr(8'h04);
    wr(8'h01);
    cnt = 0;
    repeat (6) begin
      if (issue_valid) cnt++;
      @(negedge clk);
    end
    chk(cnt == 1, "R9 single conversion", cnt, 1);
    repeat (6) @(negedge clk);
    chk(dma_req == 4'b0001, "R9 one result", dma_req, 4'b0001);
    ack(4'b0001);

    // R5 R6 R7 flush mid-sweep
    wr(8'h3D);
    chk(issue_valid && issue_ch == 2'd0, "R6 sweep start", issue_ch, 0);
    wr(8'h03);
    chk(pipe_flush == 1'b1, "R5 flush strobe", pipe_flush, 1);
    chk(!issue_valid, "R5 no issue on flush", issue_valid, 0);
    chk(rd_data == 8'h31, "R7 flush reads 0", rd_data, 8'h31);
    @(negedge clk);
    chk(!pipe_flush && issue_valid && issue_ch == 2'd2, "R6 resume ch2", issue_ch, 2);
    repeat (12) @(negedge clk);
    chk(dma_req == 4'b1100, "R5 aborted results dropped", dma_req, 4'b1100);
    ack(4'hF);

    // R11 shared request for channels 0..2
    wr(8'h81);
    wr(8'h8D);
    repeat (10) @(negedge clk);
    chk(dma_req == 4'b0000, "R11 incomplete group", dma_req, 0);
    wr(8'h91);
    repeat (8) @(negedge clk);
    chk(dma_req == 4'b0001, "R11 group complete", dma_req, 4'b0001);
    wr(8'hA1);
    repeat (8) @(negedge clk);
    chk(dma_req == 4'b1001, "R11 outside channel separate", dma_req, 4'b1001);
    ack(4'b0010);
    chk(dma_req == 4'b1001, "R11 member ack ignored", dma_req, 4'b1001);
    ack(4'b0001);
    chk(dma_req == 4'b1000, "R11 shared ack", dma_req, 4'b1000);
    ack(4'b1000);
    chk(dma_req == 4'b0000, "R11 ch3 ack", dma_req, 0);

    // Random phase, compared against the model every cycle.
    for (int k = 0; k < 2000; k++) begin
      logic [7:0] d;
      @(negedge clk);
      d = 8'($urandom);
      if ($urandom % 8 != 0) d[1] = 1'b0;
      if ($urandom % 6 != 0) d[0] = 1'b1;
      wr_en   = ($urandom % 4 == 0);
      wr_data = d;
      dma_ack = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
    end
    @(negedge clk);
    wr_en = 1'b0; dma_ack = 4'h0;
    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule